// File: doc/BRIEF.md
# Per-Element Vector Integer ALU with Predicate Generation

This block is the arithmetic stage of a small vector unit. Each cycle it takes one element operation: a 6-bit opcode, two element operands, a broadcast scalar, the element's predicate enable bit and two predicate input bits. It produces either a data result or a single predicate bit, one cycle later. A sequencer outside the block walks the element index and routes the outputs to the register files. Data results go to the data element addressed by the sequencer. Predicate bits go to one bit of a predicate register.

The opcode space has three kinds of operation. The first kind produces data: integer add, subtract and multiply, the bitwise operations, and two variants that use the broadcast scalar in place of the second element. The second kind produces a predicate: tests of one operand for zero or nonzero, an unconditional set, signed and unsigned compares, and equality of two predicate bits. The third kind is any code that is not implemented. This includes the floating-point codes. Such a code raises an illegal strobe and writes nothing.

Every result is registered. A valid bit follows the result through the register. Separate write strobes say which register file, if any, takes the value.

Top module: `vealu_top`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock cycle. When `in_valid` was 0, all of `out_data_we`, `out_pred_we` and `out_illegal` are 0.
- R2: Opcode 0x02 gives `a+b`, 0x03 gives `a-b` and 0x04 gives the low DATA_W bits of `a*b`. All three wrap modulo 2^DATA_W.
- R3: Opcode 0x05 gives the low DATA_W bits of `a*in_scalar`, and opcode 0x06 gives `a+in_scalar`. For both, `in_src_b` has no effect on the result.
- R4: Opcodes 0x09, 0x0A and 0x0B give `a&b`, `a|b` and `a^b` respectively.
- R5: The predicate bit, taken from `in_src_a`, is 1 when `a` is zero for opcode 0x0C and 1 when `a` is nonzero for opcode 0x0D. For opcode 0x0E it is always 1.
- R6: The predicate bit is `a>=b` signed for opcode 0x0F, `a<b` signed for 0x18, `a>=b` unsigned for 0x19 and `a<b` unsigned for 0x1A.
- R7: For opcode 0x14 the predicate bit is `in_pa==in_pb`. For opcode 0x17 it is `in_pa!=in_pb`.
- R8: A data opcode (0x02–0x06, 0x09–0x0B) with `in_pred`=0 still produces `out_valid`=1, but leaves `out_data_we`=0.
- R9: Opcodes 0x07, 0x08, 0x10, 0x15, 0x16 and every code not listed in R2–R7 give `out_illegal`=1 with both write strobes 0, whatever the value of `in_pred`.
- R10: At most one of `out_data_we`, `out_pred_we` and `out_illegal` is 1. Predicate opcodes assert `out_pred_we` even when `in_pred`=0.
- R11: Synchronous active-high reset clears every output to 0. An input presented in the same cycle as reset produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An element operation is presented this cycle |
| in_opcode | input | 6 | Operation code |
| in_src_a | input | DATA_W | First element operand |
| in_src_b | input | DATA_W | Second element operand |
| in_scalar | input | DATA_W | Broadcast scalar for opcodes 0x05 and 0x06 |
| in_pred | input | 1 | Element write enable for data opcodes |
| in_pa | input | 1 | First predicate input bit |
| in_pb | input | 1 | Second predicate input bit |
| out_valid | output | 1 | A result is present |
| out_data | output | DATA_W | Data result |
| out_data_we | output | 1 | Write `out_data` into the destination element |
| out_pred | output | 1 | Predicate result bit |
| out_pred_we | output | 1 | Write `out_pred` into the destination predicate bit |
| out_illegal | output | 1 | The opcode is not implemented |

## Verification
The bench builds the block with the default DATA_W of 32. At this width the sign bit is bit 31, so operands such as 0x80000000 and 0xFFFFFFFF are hand-checkable corner cases. They separate the signed compares from the unsigned ones. They also show the add, subtract and multiply results wrapping past 2^32. A multiply of 0x10000 by 0x10001 discards a carry out of bit 31, which confirms that only the low word is kept.

// File: rtl/vealu_pkg.sv
package vealu_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_ADD    = 6'h02;
    localparam logic [OPC_W-1:0] OPC_SUB    = 6'h03;
    localparam logic [OPC_W-1:0] OPC_MUL    = 6'h04;
    localparam logic [OPC_W-1:0] OPC_SMUL   = 6'h05;
    localparam logic [OPC_W-1:0] OPC_SADD   = 6'h06;
    localparam logic [OPC_W-1:0] OPC_AND    = 6'h09;
    localparam logic [OPC_W-1:0] OPC_OR     = 6'h0A;
    localparam logic [OPC_W-1:0] OPC_XOR    = 6'h0B;
    localparam logic [OPC_W-1:0] OPC_PZERO  = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_PNZ    = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_PONE   = 6'h0E;
    localparam logic [OPC_W-1:0] OPC_SGE    = 6'h0F;
    localparam logic [OPC_W-1:0] OPC_PEQ    = 6'h14;
    localparam logic [OPC_W-1:0] OPC_PNE    = 6'h17;
    localparam logic [OPC_W-1:0] OPC_SLT    = 6'h18;
    localparam logic [OPC_W-1:0] OPC_UGE    = 6'h19;
    localparam logic [OPC_W-1:0] OPC_ULT    = 6'h1A;

    typedef enum logic [1:0] {
        CLS_ILLEGAL = 2'd0,
        CLS_DATA    = 2'd1,
        CLS_PRED    = 2'd2
    } op_class_e;

    typedef enum logic [3:0] {
        FN_ADD, FN_SUB, FN_MUL, FN_AND, FN_OR, FN_XOR,
        FN_ISZERO, FN_NONZERO, FN_ALWAYS,
        FN_SGE, FN_SLT, FN_UGE, FN_ULT,
        FN_PEQ, FN_PNE, FN_NONE
    } op_fn_e;

    typedef struct packed {
        op_class_e cls;
        op_fn_e    fn;
        logic      use_scalar;
    } op_dec_t;

    function automatic logic is_pred_class(input op_class_e c);
        return c == CLS_PRED;
    endfunction

endpackage

// File: rtl/vealu_decode.sv
module vealu_decode
    import vealu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output op_dec_t          dec
);
    always_comb begin
        dec = '{cls: CLS_ILLEGAL, fn: FN_NONE, use_scalar: 1'b0};
        unique case (opcode)
            OPC_ADD:   dec = '{cls: CLS_DATA, fn: FN_ADD,     use_scalar: 1'b0};
            OPC_SUB:   dec = '{cls: CLS_DATA, fn: FN_SUB,     use_scalar: 1'b0};
            OPC_MUL:   dec = '{cls: CLS_DATA, fn: FN_MUL,     use_scalar: 1'b0};
            OPC_SMUL:  dec = '{cls: CLS_DATA, fn: FN_MUL,     use_scalar: 1'b1};
            OPC_SADD:  dec = '{cls: CLS_DATA, fn: FN_ADD,     use_scalar: 1'b1};
            OPC_AND:   dec = '{cls: CLS_DATA, fn: FN_AND,     use_scalar: 1'b0};
            OPC_OR:    dec = '{cls: CLS_DATA, fn: FN_OR,      use_scalar: 1'b0};
            OPC_XOR:   dec = '{cls: CLS_DATA, fn: FN_XOR,     use_scalar: 1'b0};
            OPC_PZERO: dec = '{cls: CLS_PRED, fn: FN_ISZERO,  use_scalar: 1'b0};
            OPC_PNZ:   dec = '{cls: CLS_PRED, fn: FN_NONZERO, use_scalar: 1'b0};
            OPC_PONE:  dec = '{cls: CLS_PRED, fn: FN_ALWAYS,  use_scalar: 1'b0};
            OPC_SGE:   dec = '{cls: CLS_PRED, fn: FN_SGE,     use_scalar: 1'b0};
            OPC_SLT:   dec = '{cls: CLS_PRED, fn: FN_SLT,     use_scalar: 1'b0};
            OPC_UGE:   dec = '{cls: CLS_PRED, fn: FN_UGE,     use_scalar: 1'b0};
            OPC_ULT:   dec = '{cls: CLS_PRED, fn: FN_ULT,     use_scalar: 1'b0};
            OPC_PEQ:   dec = '{cls: CLS_PRED, fn: FN_PEQ,     use_scalar: 1'b0};
            OPC_PNE:   dec = '{cls: CLS_PRED, fn: FN_PNE,     use_scalar: 1'b0};
            default:   dec = '{cls: CLS_ILLEGAL, fn: FN_NONE, use_scalar: 1'b0};
        endcase
    end
endmodule

// File: rtl/vealu_arith.sv
module vealu_arith
    import vealu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_fn_e            fn,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res
);
    logic [DATA_W-1:0] sum, diff, prod;

    assign sum  = opa + opb;
    assign diff = opa - opb;
    assign prod = opa * opb;

    always_comb begin
        case (fn)
            FN_ADD:  res = sum;
            FN_SUB:  res = diff;
            FN_MUL:  res = prod;
            FN_AND:  res = opa & opb;
            FN_OR:   res = opa | opb;
            FN_XOR:  res = opa ^ opb;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/vealu_predgen.sv
module vealu_predgen
    import vealu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_fn_e            fn,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              pa,
    input  logic              pb,
    output logic              pbit
);
    logic s_lt, u_lt, a_zero;

    assign s_lt   = $signed(opa) < $signed(opb);
    assign u_lt   = opa < opb;
    assign a_zero = (opa == '0);

    always_comb begin
        case (fn)
            FN_ISZERO:  pbit = a_zero;
            FN_NONZERO: pbit = !a_zero;
            FN_ALWAYS:  pbit = 1'b1;
            FN_SGE:     pbit = !s_lt;
            FN_SLT:     pbit = s_lt;
            FN_UGE:     pbit = !u_lt;
            FN_ULT:     pbit = u_lt;
            FN_PEQ:     pbit = (pa == pb);
            FN_PNE:     pbit = (pa != pb);
            default:    pbit = 1'b0;
        endcase
    end
endmodule

// File: rtl/vealu_top.sv
module vealu_top
    import vealu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [5:0]        in_opcode,
    input  logic [DATA_W-1:0] in_src_a,
    input  logic [DATA_W-1:0] in_src_b,
    input  logic [DATA_W-1:0] in_scalar,
    input  logic              in_pred,
    input  logic              in_pa,
    input  logic              in_pb,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_data_we,
    output logic              out_pred,
    output logic              out_pred_we,
    output logic              out_illegal
);
    op_dec_t           dec;
    logic [DATA_W-1:0] opb_eff;
    logic [DATA_W-1:0] arith_res;
    logic              pred_res;
    logic              is_data, is_pred, is_bad;

    vealu_decode u_dec (
        .opcode (in_opcode),
        .dec    (dec)
    );

    assign opb_eff = dec.use_scalar ? in_scalar : in_src_b;

    vealu_arith #(.DATA_W(DATA_W)) u_arith (
        .fn  (dec.fn),
        .opa (in_src_a),
        .opb (opb_eff),
        .res (arith_res)
    );

    vealu_predgen #(.DATA_W(DATA_W)) u_pgen (
        .fn   (dec.fn),
        .opa  (in_src_a),
        .opb  (in_src_b),
        .pa   (in_pa),
        .pb   (in_pb),
        .pbit (pred_res)
    );

    assign is_data = in_valid && (dec.cls == CLS_DATA);
    assign is_pred = in_valid && is_pred_class(dec.cls);
    assign is_bad  = in_valid && (dec.cls == CLS_ILLEGAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_data_we <= 1'b0;
            out_pred    <= 1'b0;
            out_pred_we <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_data    <= is_data ? arith_res : '0;
            out_data_we <= is_data && in_pred;
            out_pred    <= is_pred ? pred_res : 1'b0;
            out_pred_we <= is_pred;
            out_illegal <= is_bad;
        end
    end

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_data_we && !out_pred_we && !out_illegal));

    assert_pset_always_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_opcode == OPC_PONE) |=> (out_pred_we && out_pred));

    assert_peq_match_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_opcode == OPC_PEQ) |=> (out_pred == ($past(in_pa) == $past(in_pb))));

    assert_masked_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_pred && dec.cls == CLS_DATA) |=> (out_valid && !out_data_we));

    assert_illegal_nowrite_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec.cls == CLS_ILLEGAL) |=> (out_illegal && !out_data_we && !out_pred_we));

    assert_strobe_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_data_we, out_pred_we, out_illegal}));

    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_data_we && !out_pred_we && !out_illegal));
endmodule

// File: tb/vealu_top_test.sv
`timescale 1ns/1ps
module vealu_top_test;
    localparam int DW = 32;

    typedef struct packed {
        logic [3:0]    req;
        logic [5:0]    opc;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] s;
        logic          pred;
        logic          pa;
        logic          pb;
        logic [1:0]    kind;   // 0 data write, 1 predicate write, 2 illegal, 3 masked
        logic [DW-1:0] xd;
        logic          xp;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VECS [0:NV-1] = '{
        // R2 add, wrap, subtract, multiply
        '{4'd2, 6'h02, 32'd5,          32'd7,          32'd0, 1'b1, 1'b0, 1'b0, 2'd0, 32'd12,         1'b0},
        '{4'd2, 6'h02, 32'hFFFFFFFF,   32'd2,          32'd0, 1'b1, 1'b0, 1'b0, 2'd0, 32'd1,          1'b0},
        '{4'd2, 6'h03, 32'd3,          32'd5,          32'd0, 1'b1, 1'b0, 1'b0, 2'd0, 32'hFFFFFFFE,   1'b0},
        '{4'd2, 6'h04, 32'h00010000,   32'h00010001,   32'd0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h00010000,   1'b0},
        '{4'd2, 6'h04, 32'hFFFFFFFF,   32'd3,          32'd0, 1'b1, 1'b0, 1'b0, 2'd0, 32'hFFFFFFFD,   1'b0},
        // R3 scalar broadcast, b ignored
        '{4'd3, 6'h05, 32'd6,          32'd99,         32'd7, 1'b1, 1'b0, 1'b0, 2'd0, 32'd42,         1'b0},
        '{4'd3, 6'h06, 32'd10,         32'd1000,       32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 2'd0, 32'd9,   1'b0},
        // R4 bitwise
        '{4'd4, 6'h09, 32'hF0F0F0F0,   32'hFF00FF00,   32'd0, 1'b1, 1'b0, 1'b0, 2'd0, 32'hF000F000,   1'b0},
        '{4'd4, 6'h0A, 32'hF0F0F0F0,   32'hFF00FF00,   32'd0, 1'b1, 1'b0, 1'b0, 2'd0, 32'hFFF0FFF0,   1'b0},
        '{4'd4, 6'h0B, 32'hF0F0F0F0,   32'hFF00FF00,   32'd0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0FF00FF0,   1'b0},
        // R5 zero / nonzero / always
        '{4'd5, 6'h0C, 32'd0,          32'd5,          32'd0, 1'b1, 1'b0, 1'b0, 2'd1, 32'd0, 1'b1},
        '{4'd5, 6'h0C, 32'd1,          32'd0,          32'd0, 1'b1, 1'b0, 1'b0, 2'd1, 32'd0, 1'b0},
        '{4'd5, 6'h0D, 32'h80000000,   32'd0,          32'd0, 1'b1, 1'b0, 1'b0, 2'd1, 32'd0, 1'b1},
        '{4'd5, 6'h0D, 32'd0,          32'd7,          32'd0, 1'b1, 1'b0, 1'b0, 2'd1, 32'd0, 1'b0},
        '{4'd5, 6'h0E, 32'd0,          32'd0,          32'd0, 1'b1, 1'b0, 1'b0, 2'd1, 32'd0, 1'b1},
        // R6 compares
        '{4'd6, 6'h0F, 32'hFFFFFFFF,   32'd1,          32'd0, 1'b1, 1'b0, 1'b0, 2'd1, 32'd0, 1'b0},
        '{4'd6, 6'h0F, 32'd5,          32'd5,          32'd0, 1'b1, 1'b0, 1'b0, 2'd1, 32'd0, 1'b1},
        '{4'd6, 6'h18, 32'h80000000,   32'd0,          32'd0, 1'b1, 1'b0, 1'b0, 2'd1, 32'd0, 1'b1},
        '{4'd6, 6'h19, 32'hFFFFFFFF,   32'd1,          32'd0, 1'b1, 1'b0, 1'b0, 2'd1, 32'd0, 1'b1},
        '{4'd6, 6'h19, 32'd1,          32'd2,          32'd0, 1'b1, 1'b0, 1'b0, 2'd1, 32'd0, 1'b0},
        '{4'd6, 6'h1A, 32'h80000000,   32'd0,          32'd0, 1'b1, 1'b0, 1'b0, 2'd1, 32'd0, 1'b0},
        '{4'd6, 6'h1A, 32'd5,          32'd5,          32'd0, 1'b1, 1'b0, 1'b0, 2'd1, 32'd0, 1'b0},
        // R7 predicate equality
        '{4'd7, 6'h14, 32'd0,          32'd0,          32'd0, 1'b1, 1'b1, 1'b1, 2'd1, 32'd0, 1'b1},
        '{4'd7, 6'h14, 32'd0,          32'd0,          32'd0, 1'b1, 1'b0, 1'b1, 2'd1, 32'd0, 1'b0},
        '{4'd7, 6'h17, 32'd0,          32'd0,          32'd0, 1'b1, 1'b0, 1'b1, 2'd1, 32'd0, 1'b1},
        '{4'd7, 6'h17, 32'd0,          32'd0,          32'd0, 1'b1, 1'b0, 1'b0, 2'd1, 32'd0, 1'b0},
        // R8 masked data element
        '{4'd8, 6'h02, 32'd1,          32'd1,          32'd0, 1'b0, 1'b0, 1'b0, 2'd3, 32'd0, 1'b0},
        '{4'd8, 6'h0B, 32'd1,          32'd2,          32'd0, 1'b0, 1'b0, 1'b0, 2'd3, 32'd0, 1'b0},
        // R9 illegal codes
        '{4'd9, 6'h07, 32'd1,          32'd1,          32'd0, 1'b1, 1'b0, 1'b0, 2'd2, 32'd0, 1'b0},
        '{4'd9, 6'h08, 32'd1,          32'd1,          32'd0, 1'b1, 1'b0, 1'b0, 2'd2, 32'd0, 1'b0},
        '{4'd9, 6'h10, 32'd1,          32'd1,          32'd0, 1'b1, 1'b0, 1'b0, 2'd2, 32'd0, 1'b0},
        '{4'd9, 6'h15, 32'd1,          32'd1,          32'd0, 1'b1, 1'b0, 1'b0, 2'd2, 32'd0, 1'b0},
        '{4'd9, 6'h16, 32'd1,          32'd1,          32'd0, 0, 1'b0, 1'b0, 2'd2, 32'd0, 1'b0},
        '{4'd9, 6'h3F, 32'd0,          32'd0,          32'd0, 1'b1, 1'b0, 1'b0, 2'd2, 32'd0, 1'b0},
        '{4'd9, 6'h00, 32'd0,          32'd0,          32'd0, 1'b1, 1'b0, 1'b0, 2'd2, 32'd0, 1'b0},
        // R10 predicate op ignores element enable
        '{4'd10, 6'h0C, 32'd0,         32'd0,          32'd0, 1'b0, 1'b0, 1'b0, 2'd1, 32'd0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [5:0]    in_opcode;
    logic [DW-1:0] in_src_a, in_src_b, in_scalar;
    logic          in_pred, in_pa, in_pb;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_data_we, out_pred, out_pred_we, out_illegal;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vealu_top #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_scalar(in_scalar),
        .in_pred(in_pred), .in_pa(in_pa), .in_pb(in_pb),
        .out_valid(out_valid), .out_data(out_data), .out_data_we(out_data_we),
        .out_pred(out_pred), .out_pred_we(out_pred_we), .out_illegal(out_illegal)
    );

    task automatic chk(input int req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_strobes(input int req, input logic v, input logic dwe,
                               input logic pwe, input logic ill);
        chk(req, "out_valid",   {31'd0, out_valid},   {31'd0, v});
        chk(req, "out_data_we", {31'd0, out_data_we}, {31'd0, dwe});
        chk(req, "out_pred_we", {31'd0, out_pred_we}, {31'd0, pwe});
        chk(req, "out_illegal", {31'd0, out_illegal}, {31'd0, ill});
    endtask

    task automatic drive(input vec_t v);
        in_valid  = 1'b1;
        in_opcode = v.opc;
        in_src_a  = v.a;
        in_src_b  = v.b;
        in_scalar = v.s;
        in_pred   = v.pred;
        in_pa     = v.pa;
        in_pb     = v.pb;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0; in_opcode = '0; in_src_a = '0; in_src_b = '0;
        in_scalar = '0; in_pred = 1'b0; in_pa = 1'b0; in_pb = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk_strobes(11, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(11, "out_data", out_data, '0);
        rst = 1'b0;

        // table walk, back to back
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(posedge clk);
            @(negedge clk);
            case (VECS[i].kind)
                2'd0: begin
                    chk_strobes(int'(VECS[i].req), 1'b1, 1'b1, 1'b0, 1'b0);
                    chk(int'(VECS[i].req), "out_data", out_data, VECS[i].xd);
                end
                2'd1: begin
                    chk_strobes(int'(VECS[i].req), 1'b1, 1'b0, 1'b1, 1'b0);
                    chk(int'(VECS[i].req), "out_pred", {31'd0, out_pred}, {31'd0, VECS[i].xp});
                end
                2'd2: chk_strobes(int'(VECS[i].req), 1'b1, 1'b0, 1'b0, 1'b1);
                default: chk_strobes(int'(VECS[i].req), 1'b1, 1'b0, 1'b0, 1'b0);
            endcase
        end

        // R1: bubble gives no valid and no strobes
        in_valid = 1'b0;
        in_opcode = 6'h02;
        in_pred = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_strobes(1, 1'b0, 1'b0, 1'b0, 1'b0);

        // R1: valid returns after a bubble
        drive(VECS[0]);
        @(posedge clk);
        @(negedge clk);
        chk_strobes(1, 1'b1, 1'b1, 1'b0, 1'b0);
        chk(1, "out_data", out_data, 32'd12);

        // R11: an input presented together with reset produces nothing
        rst = 1'b1;
        drive(VECS[0]);
        @(posedge clk);
        @(negedge clk);
        chk_strobes(11, 1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_strobes(11, 1'b0, 1'b0, 1'b0, 1'b0);

        finish_run();
    end
endmodule